// File: doc/BRIEF.md
# Segmented Scan Shift Controller

This block owns a scan chain that is cut into a fixed number of equal segments and sequences its shift so that only one segment is clocked in any cycle. Every other segment has its clock enable held low, so it keeps its contents. A single shift request unloads the previous response and loads the next pattern. The segments are visited in turn, starting with the lowest. While a segment is active, the output multiplexer routes that segment's exit bit to the chain's scan output, and the scan input feeds the segment's entry bit.

When scan enable is low, the block is in functional or capture mode. All segment enables are then high together and every flop loads its functional data input. The functional data path passes only through the usual scan multiplexer in front of each flop and gains no extra logic, so launch-on-capture works with all segments clocked at once.

The segment length can be programmed up to a build-time maximum. It is sampled when a shift sequence starts, so the full chain takes exactly segments times length shift cycles. A one-cycle done pulse marks the end of the sequence. Dropping scan enable in the middle of a sequence abandons it.

Top module: `segscan_ctrl`

## Requirements
- R1: After reset, all segment enables are low while scan enable is high, done is low, the output select is 0 and every segment flop holds 0.
- R2: While scan enable is low, every segment enable is high. At each clock edge the whole chain loads func_d, where bit k*SEG_MAX+b of func_d goes to bit b of segment k.
- R3: A shift request seen while idle with scan enable high starts a sequence at the next edge. Segment 0 is clocked first, then 1, 2 and so on, each for exactly the sampled length in cycles. The output select shows the index of the active segment.
- R4: While scan enable is high, at most one segment enable is high in any cycle.
- R5: In the active segment, bit 0 takes scan_in and every bit moves up one position at each edge. scan_out equals bit (length-1) of the selected segment. The response bits therefore leave oldest first while the new pattern enters. Segment k's flops appear on seg_q[k*SEG_MAX +: SEG_MAX].
- R6: A segment whose enable is low keeps its contents unchanged.
- R7: done is high for exactly one cycle: the cycle after the last shift cycle of the last segment. The number of cycles with an enable high in a sequence equals NUM_SEG times the length, and done is low throughout the sequence.
- R8: The length is sampled when a sequence starts. A value of 0 or a value above SEG_MAX is treated as SEG_MAX. Changes to seg_len during a sequence have no effect on it.
- R9: If scan enable goes low during a sequence, the sequence is abandoned without a done pulse. When scan enable returns, the block is idle with all enables low and the select at 0, and the next sequence starts again at segment 0.
- R10: A shift request that arrives while a sequence is running is ignored. The sequence ends at its original cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | High: scan shift mode; low: functional or capture mode |
| shift_req | input | 1 | One-cycle pulse that starts a shift sequence |
| seg_len | input | LEN_W | Programmed segment length |
| scan_in | input | 1 | Serial scan data into the active segment |
| func_d | input | NUM_SEG*SEG_MAX | Functional data for every chain flop |
| seg_ce | output | NUM_SEG | Clock enable for each segment |
| out_sel | output | SEL_W | Select of the output multiplexer (active segment) |
| scan_out | output | 1 | Exit bit of the selected segment |
| done | output | 1 | One-cycle pulse when a sequence completes |
| seg_q | output | NUM_SEG*SEG_MAX | Contents of all chain flops |

## Verification
Before any sequence, a capture loads a non-trivial word into the chain, so the first unload returns known data rather than zeros. A table of sequences then covers the full length, short lengths, a length of one, and the two lengths that must be clamped. Each is driven with its own scan-in word, so a wrong tap, a wrong segment order or a wrong shift count shows up as a different unloaded stream or a different final chain image. Directed runs inject a request and a length change in the middle of a sequence, which separates the sampled length from the live one. They also drop scan enable partway through a segment, which shows whether an aborted sequence restarts at segment 0 and produces no done pulse.

// File: rtl/segscan_pkg.sv
package segscan_pkg;
  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/segscan_bank.sv
// One chain segment: scan mux in front of each flop, clock enable modelled as a hold.
module segscan_bank #(
  parameter int SEG_MAX = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               scan_mode,
  input  logic               si,
  input  logic [SEG_MAX-1:0] func_d,
  output logic [SEG_MAX-1:0] q
);

  logic [SEG_MAX-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ce) begin
      if (scan_mode) q_nxt = {q[SEG_MAX-2:0], si};
      else           q_nxt = func_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R2
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !scan_mode) |=> (q == $past(func_d)));

  // R6
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(q));

  // R5
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && scan_mode) |=> (q[0] == $past(si)));

endmodule

// File: rtl/segscan_tap.sv
// Output multiplexer: picks the exit bit (length-1) of the selected segment.
module segscan_tap #(
  parameter int NUM_SEG = 4,
  parameter int SEG_MAX = 8,
  parameter int LEN_W   = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_SEG*SEG_MAX-1:0] q_flat,
  input  logic [SEL_W-1:0]           sel,
  input  logic [LEN_W-1:0]           len,
  output logic                       so
);

  always_comb begin
    so = 1'b0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (SEL_W'(s) == sel) begin
        for (int b = 0; b < SEG_MAX; b++) begin
          if (LEN_W'(b + 1) == len) so = q_flat[s*SEG_MAX + b];
        end
      end
    end
  end

endmodule

// File: rtl/segscan_seq.sv
// Shift sequencer: walks the segments in order and counts each one's length.
module segscan_seq
  import segscan_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEG_MAX = 8,
  parameter int LEN_W   = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               shift_req,
  input  logic [LEN_W-1:0]   seg_len,
  output logic [NUM_SEG-1:0] seg_ce,
  output logic [SEL_W-1:0]   seg_idx,
  output logic [LEN_W-1:0]   len_q,
  output logic               done
);

  localparam logic [SEL_W-1:0] LAST_SEG = SEL_W'(NUM_SEG - 1);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(SEG_MAX);

  seq_state_e       state, state_nxt;
  logic [SEL_W-1:0] idx_nxt;
  logic [LEN_W-1:0] cnt, cnt_nxt, len_nxt, len_eff;
  logic             done_nxt;

  assign len_eff = ((seg_len == '0) || (seg_len > FULL_LEN)) ? FULL_LEN : seg_len;

  always_comb begin
    state_nxt = state;
    idx_nxt   = seg_idx;
    cnt_nxt   = cnt;
    len_nxt   = len_q;
    done_nxt  = 1'b0;
    if (!scan_en) begin
      state_nxt = SQ_IDLE;
      idx_nxt   = '0;
      cnt_nxt   = '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (shift_req) begin
            state_nxt = SQ_SHIFT;
            idx_nxt   = '0;
            cnt_nxt   = '0;
            len_nxt   = len_eff;
          end
        end
        SQ_SHIFT: begin
          if (cnt == (len_q - LEN_W'(1))) begin
            cnt_nxt = '0;
            if (seg_idx == LAST_SEG) begin
              state_nxt = SQ_IDLE;
              idx_nxt   = '0;
              done_nxt  = 1'b1;
            end else begin
              idx_nxt = seg_idx + SEL_W'(1);
            end
          end else begin
            cnt_nxt = cnt + LEN_W'(1);
          end
        end
        default: state_nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      seg_idx <= '0;
      cnt     <= '0;
      len_q   <= FULL_LEN;
      done    <= 1'b0;
    end else begin
      state   <= state_nxt;
      seg_idx <= idx_nxt;
      cnt     <= cnt_nxt;
      len_q   <= len_nxt;
      done    <= done_nxt;
    end
  end

  always_comb begin
    if (!scan_en) begin
      seg_ce = '1;
    end else begin
      seg_ce = '0;
      for (int s = 0; s < NUM_SEG; s++) begin
        if ((state == SQ_SHIFT) && (SEL_W'(s) == seg_idx)) seg_ce[s] = 1'b1;
      end
    end
  end

  // R4
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> $onehot0(seg_ce));

  // R7
  done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state) == SQ_SHIFT) && (state == SQ_IDLE));

  // R8
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SQ_SHIFT) && ($past(state) == SQ_SHIFT)) |-> $stable(len_q));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_SHIFT) |-> (cnt < len_q));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> ((state == SQ_IDLE) && (seg_idx == '0) && !done));

endmodule

// File: rtl/segscan_ctrl.sv
module segscan_ctrl #(
  parameter int NUM_SEG = 4,
  parameter int SEG_MAX = 8,
  parameter int LEN_W   = $clog2(SEG_MAX + 1),
  parameter int SEL_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  parameter int CHAIN_W = NUM_SEG * SEG_MAX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               shift_req,
  input  logic [LEN_W-1:0]   seg_len,
  input  logic               scan_in,
  input  logic [CHAIN_W-1:0] func_d,
  output logic [NUM_SEG-1:0] seg_ce,
  output logic [SEL_W-1:0]   out_sel,
  output logic               scan_out,
  output logic               done,
  output logic [CHAIN_W-1:0] seg_q
);

  logic [LEN_W-1:0] len_q;

  segscan_seq #(
    .NUM_SEG(NUM_SEG), .SEG_MAX(SEG_MAX), .LEN_W(LEN_W), .SEL_W(SEL_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .shift_req(shift_req),
    .seg_len(seg_len), .seg_ce(seg_ce), .seg_idx(out_sel), .len_q(len_q),
    .done(done)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    segscan_bank #(.SEG_MAX(SEG_MAX)) u_bank (
      .clk(clk), .rst_n(rst_n), .ce(seg_ce[g]), .scan_mode(scan_en),
      .si(scan_in), .func_d(func_d[g*SEG_MAX +: SEG_MAX]),
      .q(seg_q[g*SEG_MAX +: SEG_MAX])
    );
  end

  segscan_tap #(
    .NUM_SEG(NUM_SEG), .SEG_MAX(SEG_MAX), .LEN_W(LEN_W), .SEL_W(SEL_W)
  ) u_tap (
    .q_flat(seg_q), .sel(out_sel), .len(len_q), .so(scan_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done && (out_sel == '0)));

endmodule

// File: tb/segscan_ctrl_tb.sv
module segscan_ctrl_tb;
  localparam int NUM_SEG = 4;
  localparam int SEG_MAX = 8;
  localparam int LEN_W   = 4;
  localparam int SEL_W   = 2;
  localparam int CHAIN_W = NUM_SEG * SEG_MAX;
  localparam int NVEC    = 6;

  // stimulus: programmed length, scan-in word; expected: effective length
  localparam logic [LEN_W-1:0] VLEN [NVEC] = '{4'd8, 4'd3, 4'd1, 4'd0, 4'd12, 4'd5};
  localparam logic [31:0]      VPAT [NVEC] = '{32'hA5A5_F00F, 32'h1234_5678, 32'h0000_000B,
                                               32'hDEAD_BEEF, 32'h0F0F_3C3C, 32'h8001_7FFE};
  localparam int               VEFF [NVEC] = '{8, 3, 1, 8, 8, 5};

  logic clk = 1'b0;
  logic rst_n, scan_en, shift_req, scan_in;
  logic [LEN_W-1:0]   seg_len;
  logic [CHAIN_W-1:0] func_d;
  logic [NUM_SEG-1:0] seg_ce;
  logic [SEL_W-1:0]   out_sel;
  logic               scan_out, done;
  logic [CHAIN_W-1:0] seg_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [SEG_MAX-1:0] m [NUM_SEG];

  always #2 clk = ~clk;

  segscan_ctrl #(.NUM_SEG(NUM_SEG), .SEG_MAX(SEG_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .shift_req(shift_req),
    .seg_len(seg_len), .scan_in(scan_in), .func_d(func_d), .seg_ce(seg_ce),
    .out_sel(out_sel), .scan_out(scan_out), .done(done), .seg_q(seg_q)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CHAIN_W-1:0] model_flat();
    logic [CHAIN_W-1:0] f;
    for (int k = 0; k < NUM_SEG; k++) f[k*SEG_MAX +: SEG_MAX] = m[k];
    return f;
  endfunction

  task automatic load_model(input logic [CHAIN_W-1:0] f);
    for (int k = 0; k < NUM_SEG; k++) m[k] = f[k*SEG_MAX +: SEG_MAX];
  endtask

  // full sequence; poke >= 0 injects a request and a length change at that cycle
  task automatic run_shift(input logic [LEN_W-1:0] len_in, input logic [31:0] pat,
                           input int eff, input int poke, input string tag);
    logic [63:0] got, exp_s, mask;
    int bad_ce, bad_sel, bad_done, total, a;
    got = '0; exp_s = '0; bad_ce = 0; bad_sel = 0; bad_done = 0;
    total = NUM_SEG * eff;
    mask = (64'd1 << total) - 64'd1;
    @(negedge clk);
    seg_len = len_in; shift_req = 1'b1;
    @(negedge clk);
    shift_req = 1'b0;
    for (int i = 0; i < total; i++) begin
      a = i / eff;
      exp_s[i] = m[a][eff-1];
      got[i]   = scan_out;
      if (seg_ce != (NUM_SEG'(1) << a)) bad_ce++;
      if (out_sel != SEL_W'(a)) bad_sel++;
      if (done) bad_done++;
      if (i == poke) begin shift_req = 1'b1; seg_len = 4'd2; end
      else shift_req = 1'b0;
      scan_in = pat[i];
      m[a] = {m[a][SEG_MAX-2:0], pat[i]};
      @(negedge clk);
    end
    shift_req = 1'b0;
    chk((got & mask) == (exp_s & mask), {"R5 unload stream ", tag}, got & mask, exp_s & mask);
    chk(bad_ce == 0, {"R4/R3 one enable in order ", tag}, bad_ce, 0);
    chk(bad_sel == 0, {"R3 select follows segment ", tag}, bad_sel, 0);
    chk(bad_done == 0, {"R7 done low during shift ", tag}, bad_done, 0);
    chk(done == 1'b1, {"R7 R8 R10 done after N*len cycles ", tag}, done, 1);
    chk(seg_ce == '0, {"R6 all held after sequence ", tag}, seg_ce, 0);
    chk(seg_q == model_flat(), {"R5 R6 chain image ", tag}, seg_q, model_flat());
    @(negedge clk);
    chk(done == 1'b0, {"R7 done one cycle ", tag}, done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scan_en = 1'b1; shift_req = 1'b0; scan_in = 1'b0;
    seg_len = 4'd4; func_d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seg_ce == '0, "R1 enables low", seg_ce, 0);
    chk(done == 1'b0, "R1 done low", done, 0);
    chk(out_sel == '0, "R1 select zero", out_sel, 0);
    chk(seg_q == '0, "R1 chain zero", seg_q, 0);

    // capture: all segments clocked together
    scan_en = 1'b0; func_d = 32'hC3A5_1E96;
    #0.5;
    chk(seg_ce == '1, "R2 all enables in capture", seg_ce, 4'hF);
    @(negedge clk);
    chk(seg_q == 32'hC3A5_1E96, "R2 capture load", seg_q, 32'hC3A5_1E96);
    scan_en = 1'b1; func_d = '0;
    @(negedge clk);
    chk(seg_ce == '0 && seg_q == 32'hC3A5_1E96, "R6 idle hold", seg_q, 32'hC3A5_1E96);
    load_model(32'hC3A5_1E96);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      run_shift(VLEN[v], VPAT[v], VEFF[v], -1, $sformatf("vec%0d", v));
    end

    // R8 R10: request and length change mid-sequence are ignored
    run_shift(4'd4, 32'h3C96_A55A, 4, 5, "midreq");

    // R9: abort in segment 1
    @(negedge clk);
    seg_len = 4'd4; shift_req = 1'b1;
    @(negedge clk);
    shift_req = 1'b0;
    for (int i = 0; i < 6; i++) begin
      scan_in = i[0];
      @(negedge clk);
    end
    scan_en = 1'b0; func_d = 32'h5A5A_0FF0;
    @(negedge clk);
    chk(done == 1'b0, "R9 no done on abort", done, 0);
    chk(seg_q == 32'h5A5A_0FF0, "R9 R2 capture after abort", seg_q, 32'h5A5A_0FF0);
    scan_en = 1'b1;
    @(negedge clk);
    chk(seg_ce == '0 && out_sel == '0, "R9 idle after abort", {seg_ce, out_sel}, 0);
    chk(done == 1'b0, "R9 still no done", done, 0);
    load_model(32'h5A5A_0FF0);
    run_shift(4'd2, 32'h0000_00C9, 2, -1, "restart");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule